// File: doc/BRIEF.md
# Receive Cell Filter

This block sits between a receive cell deframer and the receive FIFO of a cell-based physical layer. The deframer hands it one byte per clock. A start marker comes with the first byte of a cell and an end marker with the last. On the end byte the deframer also raises two flags: one for an invalid command code and one for a header check failure. The filter stores each cell in a one-cell buffer. It decides at the end of the cell whether to keep it, and only then writes a kept cell to the FIFO write port, byte by byte, with its own start and end markers.

Three static controls set the policy. One enables header check errors. One discards errored cells. One discards idle cells, which are cells whose header carries zero flow-control and path/channel identifiers. The filter also measures each cell's length, so a cell that ends early counts as a short cell. Any cell error produces a one-cycle event pulse for the interrupt logic. While a kept cell drains into the FIFO, the filter holds off the deframer. A full FIFO stalls the drain.

Top module: `rx_cell_filter`

## Requirements
- R1: No FIFO write for a cell occurs until its end byte has been accepted. `in_ready` is low from the cycle after a kept cell's end byte until its last byte is written, and high at all other times after reset.
- R2: A kept cell is written in arrival order. `fifo_sop` is high with the first byte only, and `fifo_eop` is high with the last byte only.
- R3: A cell whose end byte arrives before `CELL_BYTES` bytes have been accepted is a short cell. Bytes accepted beyond the `CELL_BYTES`-th byte of a cell are not stored, so a long cell that is kept is written with exactly `CELL_BYTES` bytes.
- R4: A cell is errored when it is short, or when `in_cmd_err` is high on its end byte, or when `in_hec_err` is high on its end byte while `cfg_hec_chk` is 1. `in_hec_err` has no effect while `cfg_hec_chk` is 0.
- R5: While `cfg_drop_err` is 1, an errored cell is never written to the FIFO. While it is 0, an errored cell is written with the bytes it has.
- R6: A cell is idle when it has at least 4 bytes, bytes 0 to 2 are zero, and bits 7:4 of byte 3 are zero. Bits 3:0 of byte 3 are ignored. While `cfg_drop_idle` is 1, an idle cell is not written and raises no event of its own.
- R7: `cell_err_evt` is high for exactly the one cycle after an errored cell's end byte is accepted. This happens whether the cell is discarded or not.
- R8: While `fifo_full` is 1, `fifo_wr` is 0 and the byte on offer is held. No byte is lost or repeated.
- R9: After reset, `in_ready` is 1 and `fifo_wr` and `cell_err_evt` are 0.
- R10: A byte accepted with `in_sop` low while no cell is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_drop_err | input | 1 | Discard errored cells |
| cfg_drop_idle | input | 1 | Discard idle cells |
| cfg_hec_chk | input | 1 | Count header check failures as errors |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Filter can accept a byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a cell |
| in_eop | input | 1 | Last byte of a cell |
| in_cmd_err | input | 1 | Invalid command code, valid with in_eop |
| in_hec_err | input | 1 | Header check failure, valid with in_eop |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write byte |
| fifo_sop | output | 1 | Written byte is the first of a cell |
| fifo_eop | output | 1 | Written byte is the last of a cell |
| fifo_full | input | 1 | FIFO cannot take a byte |
| cell_err_evt | output | 1 | One-cycle cell error pulse |

## Verification
The bench builds the filter with `CELL_BYTES` set to 8. This keeps the four header bytes but makes each cell short enough to sweep the whole policy space. The sweep covers all eight control settings, four lengths (well short, one short, exact, two long), and all eight combinations of idle header, command error and header check error. That is 256 cells in total. Some cells are led by a stray byte, and on half of the cells the FIFO full input toggles pseudo-randomly. The expected kept length, byte values and event count of every cell are worked out from the requirements. One extra case holds the FIFO full for a long stretch.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 4;

  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } rxf_state_e;

  // Header bits that must be zero at byte position pos for an idle cell.
  function automatic logic hdr_byte_clear(input logic [BYTE_W-1:0] b, input int pos);
    if (pos < HDR_BYTES - 1) return (b == '0);
    else if (pos == HDR_BYTES - 1) return (b[BYTE_W-1:BYTE_W/2] == '0);
    else return 1'b1;
  endfunction
endpackage

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  localparam int IDX_W = $clog2(CELL_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] data,
  input  logic              sop,
  input  logic              eop,
  input  logic              cmd_err,
  input  logic              hec_err,
  input  logic              hec_chk,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              done,
  output logic              err,
  output logic              idle,
  output logic [IDX_W-1:0]  done_len
);
  localparam logic [IDX_W-1:0] FULL_CNT = IDX_W'(CELL_BYTES);
  localparam logic [IDX_W-1:0] HDR_CNT  = IDX_W'(HDR_BYTES);

  logic             open_q, open_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             idle_q, idle_d;
  logic             active;
  logic [IDX_W-1:0] idx, new_cnt;
  logic             idle_next, short_cell;

  always_comb begin
    active     = take && (sop || open_q);
    idx        = sop ? '0 : cnt_q;
    new_cnt    = (idx < FULL_CNT) ? idx + 1'b1 : idx;
    idle_next  = (sop ? 1'b1 : idle_q) && hdr_byte_clear(data, int'(idx));
    wr_en      = active && (idx < FULL_CNT);
    wr_idx     = idx;
    done       = active && eop;
    short_cell = new_cnt < FULL_CNT;
    err        = short_cell || cmd_err || (hec_err && hec_chk);
    idle       = idle_next && (new_cnt >= HDR_CNT);
    done_len   = new_cnt;
    open_d     = open_q;
    cnt_d      = cnt_q;
    idle_d     = idle_q;
    if (active) begin
      open_d = !eop;
      cnt_d  = new_cnt;
      idle_d = idle_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
      idle_q <= idle_d;
    end
  end

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  a_r10_no_store_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !sop) |-> !wr_en);
endmodule

// File: rtl/rxf_cell_buf.sv
module rxf_cell_buf
  import rxf_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  localparam int IDX_W = $clog2(CELL_BYTES + 1)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0]     mem [CELL_BYTES];
  logic [CELL_BYTES-1:0] wen;

  for (genvar e = 0; e < CELL_BYTES; e++) begin : g_wdec
    assign wen[e] = wr_en && (wr_idx == IDX_W'(e));
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < CELL_BYTES; e++) begin
      if (wen[e]) mem[e] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int e = 0; e < CELL_BYTES; e++) begin
      if (rd_idx == IDX_W'(e)) rd_data = mem[e];
    end
  end
endmodule

// File: rtl/rxf_drain.sv
module rxf_drain
  import rxf_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  localparam int IDX_W = $clog2(CELL_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_len,
  input  logic             fifo_full,
  output logic             in_ready,
  output logic             fifo_wr,
  output logic             fifo_sop,
  output logic             fifo_eop,
  output logic [IDX_W-1:0] rd_idx
);
  rxf_state_e       state_q, state_d;
  logic [IDX_W-1:0] rd_q, rd_d;
  logic [IDX_W-1:0] len_q, len_d;
  logic             last;

  always_comb begin
    last     = (rd_q == len_q - 1'b1);
    in_ready = (state_q == ST_FILL);
    fifo_wr  = (state_q == ST_DRAIN) && !fifo_full;
    fifo_sop = (state_q == ST_DRAIN) && (rd_q == '0);
    fifo_eop = (state_q == ST_DRAIN) && last;
    rd_idx   = rd_q;
    state_d  = state_q;
    rd_d     = rd_q;
    len_d    = len_q;
    case (state_q)
      ST_FILL: if (start) begin
        state_d = ST_DRAIN;
        rd_d    = '0;
        len_d   = start_len;
      end
      default: if (fifo_wr) begin
        if (last) state_d = ST_FILL;
        else      rd_d    = rd_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      rd_q    <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      len_q   <= len_d;
    end
  end

  a_r8_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr);
  a_r8_hold_index: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && fifo_full) |=> $stable(rd_q));
  a_r1_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !fifo_eop) |=> !in_ready);
  a_r2_back_to_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_eop) |=> in_ready);
endmodule

// File: rtl/rx_cell_filter.sv
module rx_cell_filter
  import rxf_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  localparam int IDX_W = $clog2(CELL_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_drop_err,
  input  logic              cfg_drop_idle,
  input  logic              cfg_hec_chk,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_cmd_err,
  input  logic              in_hec_err,
  output logic              fifo_wr,
  output logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_sop,
  output logic              fifo_eop,
  input  logic              fifo_full,
  output logic              cell_err_evt
);
  logic [1:0]       rst_sync;
  logic             rst_q;
  logic             take;
  logic             buf_we;
  logic [IDX_W-1:0] buf_widx, rd_idx, done_len;
  logic             done, err, idle, keep, start;
  logic             evt_q, evt_d;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign take = in_valid && in_ready;

  rxf_classify #(.CELL_BYTES(CELL_BYTES)) u_class (
    .clk      (clk),
    .rst_n    (rst_q),
    .take     (take),
    .data     (in_data),
    .sop      (in_sop),
    .eop      (in_eop),
    .cmd_err  (in_cmd_err),
    .hec_err  (in_hec_err),
    .hec_chk  (cfg_hec_chk),
    .wr_en    (buf_we),
    .wr_idx   (buf_widx),
    .done     (done),
    .err      (err),
    .idle     (idle),
    .done_len (done_len)
  );

  rxf_cell_buf #(.CELL_BYTES(CELL_BYTES)) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (buf_widx),
    .wr_data (in_data),
    .rd_idx  (rd_idx),
    .rd_data (fifo_data)
  );

  always_comb begin
    keep  = !((err && cfg_drop_err) || (idle && cfg_drop_idle));
    start = done && keep;
    evt_d = done && err;
  end

  rxf_drain #(.CELL_BYTES(CELL_BYTES)) u_drain (
    .clk       (clk),
    .rst_n     (rst_q),
    .start     (start),
    .start_len (done_len),
    .fifo_full (fifo_full),
    .in_ready  (in_ready),
    .fifo_wr   (fifo_wr),
    .fifo_sop  (fifo_sop),
    .fifo_eop  (fifo_eop),
    .rd_idx    (rd_idx)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end
  assign cell_err_evt = evt_q;

  a_r7_evt_follows_eop: assert property (@(posedge clk) disable iff (!rst_q)
    cell_err_evt |-> $past(in_valid && in_ready && in_eop));
  a_r1_no_store_busy: assert property (@(posedge clk) disable iff (!rst_q)
    !in_ready |-> !buf_we);
  a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_q)
    (!in_ready && fifo_full) |=> $stable(fifo_data));
endmodule

// File: tb/sim_rx_cell_filter.sv
`timescale 1ns/1ps
module sim_rx_cell_filter;
  localparam int CB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_drop_err = 1'b0, cfg_drop_idle = 1'b0, cfg_hec_chk = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic in_cmd_err = 1'b0, in_hec_err = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic fifo_full = 1'b0;
  logic in_ready, fifo_wr, fifo_sop, fifo_eop, cell_err_evt;
  logic [7:0] fifo_data;

  int n_chk = 0, n_err = 0;
  int got_cnt = 0, evt_cnt = 0, wr_in_send = 0;
  logic [7:0] got [16];
  logic got_sop [16];
  logic got_eop [16];
  bit sending = 0, mon_on = 0, full_en = 0, full_force = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  rx_cell_filter #(.CELL_BYTES(CB)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_drop_err(cfg_drop_err), .cfg_drop_idle(cfg_drop_idle), .cfg_hec_chk(cfg_hec_chk),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_cmd_err(in_cmd_err), .in_hec_err(in_hec_err),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_sop(fifo_sop), .fifo_eop(fifo_eop),
    .fifo_full(fifo_full), .cell_err_evt(cell_err_evt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // FIFO full driver and output monitor, both just after the falling edge.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    fifo_full = full_force || (full_en && lfsr[0] && lfsr[3]);
    #1;
    if (mon_on) begin
      if (fifo_wr) begin
        if (got_cnt < 16) begin
          got[got_cnt] = fifo_data;
          got_sop[got_cnt] = fifo_sop;
          got_eop[got_cnt] = fifo_eop;
        end
        got_cnt++;
        if (sending) wr_in_send++;
      end
      if (cell_err_evt) evt_cnt++;
    end
  end

  function automatic logic [7:0] pat(input int c, input int i, input bit idl);
    logic [7:0] v;
    if (idl && i < 3) return 8'h00;
    if (idl && i == 3) return 8'h01;
    v = 8'((c * 7 + i * 13 + 1) & 255);
    if (i == 0) v = v | 8'h80;
    return v;
  endfunction

  task automatic put_byte(input logic [7:0] d, input bit s, input bit e,
                          input bit cm, input bit hc);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    in_cmd_err = cm; in_hec_err = hc;
  endtask

  task automatic send_cell(input int c, input int len, input bit idl, input bit cm,
                           input bit hc, input bit stray);
    bit shrt, isidle, er, drop;
    int exp_len;
    string tag;
    shrt    = len < CB;
    isidle  = idl && len >= 4;
    er      = shrt || cm || (hc && cfg_hec_chk);
    drop    = (er && cfg_drop_err) || (isidle && cfg_drop_idle);
    exp_len = drop ? 0 : (len < CB ? len : CB);
    @(negedge clk); #2;
    got_cnt = 0; evt_cnt = 0; wr_in_send = 0; sending = 1;
    if (stray) put_byte(8'h5A, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < len; i++)
      put_byte(pat(c, i, idl), i == 0, i == len - 1, cm && i == len - 1, hc && i == len - 1);
    @(negedge clk);
    sending = 0;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_cmd_err = 1'b0; in_hec_err = 1'b0;
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    #2;
    if (drop && er && cfg_drop_err) tag = "R5 discard errored";
    else if (drop)                  tag = "R6 discard idle";
    else if (len > CB)              tag = "R3 long cell trimmed";
    else if (stray)                 tag = "R10 stray byte ignored";
    else if (full_en)               tag = "R8 byte count under full";
    else                            tag = "R2 byte count";
    chk(got_cnt == exp_len, tag, got_cnt, exp_len);
    chk(wr_in_send == 0, "R1 write before end byte", wr_in_send, 0);
    chk(evt_cnt == int'(er), "R4 R7 error event count", evt_cnt, int'(er));
    for (int i = 0; i < exp_len && i < 16 && got_cnt == exp_len; i++) begin
      chk(got[i] == pat(c, i, idl), "R2 byte value", got[i], pat(c, i, idl));
      chk(got_sop[i] == (i == 0), "R2 start marker", got_sop[i], i == 0);
      chk(got_eop[i] == (i == exp_len - 1), "R2 end marker", got_eop[i], i == exp_len - 1);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int c;
    int lens [4];
    lens[0] = 3; lens[1] = CB - 1; lens[2] = CB; lens[3] = CB + 2;
    c = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
    chk(fifo_wr == 1'b0, "R9 no write after reset", fifo_wr, 0);
    chk(cell_err_evt == 1'b0, "R9 no event after reset", cell_err_evt, 0);
    mon_on = 1;
    for (int cfg = 0; cfg < 8; cfg++) begin
      cfg_drop_err  = cfg[0];
      cfg_drop_idle = cfg[1];
      cfg_hec_chk   = cfg[2];
      for (int li = 0; li < 4; li++) begin
        for (int fl = 0; fl < 8; fl++) begin
          full_en = ((li + fl) % 2) == 1;
          send_cell(c, lens[li], fl[0], fl[1], fl[2], fl == 5);
          c++;
        end
      end
    end
    // Long stall: FIFO held full through a whole kept cell.
    full_en = 0; cfg_drop_err = 0; cfg_drop_idle = 0; cfg_hec_chk = 0;
    @(negedge clk); #2;
    got_cnt = 0; evt_cnt = 0; full_force = 1;
    for (int i = 0; i < CB; i++) put_byte(pat(c, i, 0), i == 0, i == CB - 1, 0, 0);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    repeat (20) @(negedge clk);
    #2;
    chk(got_cnt == 0, "R8 no write while full", got_cnt, 0);
    chk(in_ready == 1'b0, "R8 R1 upstream held while full", in_ready, 0);
    full_force = 0;
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    #2;
    chk(got_cnt == CB, "R8 cell delivered after stall", got_cnt, CB);
    for (int i = 0; i < CB && got_cnt == CB; i++)
      chk(got[i] == pat(c, i, 0), "R8 byte after stall", got[i], pat(c, i, 0));
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule